// File: doc/BRIEF.md
# DC-Link Voltage Command Scheduler

This block sets the voltage command for the DC-link of a single-phase boost rectifier, based on how strong the grid is. It averages the d-axis grid voltage sample over a fixed window of sample strobes. The default window is 10,000 strobes, which is one second at a 10 kHz sample rate. The result is an estimate of the grid peak voltage. After each window it publishes that estimate with a one-cycle strobe.

At each window boundary, and only there, the estimate is placed into one of seven grid bands. The band boundaries carry hysteresis. Each band selects a DC-link target, from 190 V in the lowest band to 250 V in the highest, in 10 V steps.

The command output does not jump to the target. A start pulse loads the command with the measured DC-link voltage plus a 20 V offset. After that, each sample strobe moves the command toward the target by a bounded step.

All voltages use an unsigned fixed-point scale of 1/8 V per LSB.

Top module: `dcl_cmd_sched`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, peak_est, peak_vld and cmd_out are all zero.
- R2: peak_vld goes high for exactly one cycle, two clock cycles after the cycle that carries the N_AVG-th accepted strobe of a window. A strobe is accepted only when smp_vld is high. The next window starts counting with the following strobe.
- R3: peak_est equals floor(S * RC / 2^32). Here S is the exact sum of the window's vd_in samples and RC = ceil(2^32 / N_AVG). A window of constant samples therefore reports that constant exactly. This includes full scale 65535, so the sum never overflows.
- R4: Grid bands are numbered 0 to 6. Edge k (k = 0..5) lies between band k and band k+1, at threshold T_k = floor((740 + 40k) * 181 / 128). The new band is the number of edges the estimate passes. An edge at or above the current band is passed when the estimate is at least T_k + 8. An edge below the current band stays passed while the estimate is at least T_k - 8.
- R5: The target is 1520 + 80 * band (190 V to 250 V). It changes only on the clock edge that samples peak_vld high. Its reset value is 1520.
- R6: On the edge that samples start high, cmd_out becomes vdc_meas + 160 (20 V) and the ramp is armed. A later start reloads the command in the same way.
- R7: While armed, and once at least one target has been evaluated, each sampled strobe moves cmd_out toward the target by RAMP_STEP LSB (default 2). When the gap is smaller than that, cmd_out lands exactly on the target and never passes it.
- R8: Before the first start, cmd_out stays zero whatever the strobes and samples do. After start but before the first target evaluation, cmd_out holds the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; qualifies vd_in and advances the ramp |
| start | input | 1 | Start pulse; loads the command from vdc_meas |
| vd_in | input | 16 | d-axis grid voltage sample, 1/8 V per LSB |
| vdc_meas | input | 16 | Measured DC-link voltage, 1/8 V per LSB |
| peak_est | output | 16 | Grid peak estimate, the mean of the last window |
| peak_vld | output | 1 | One-cycle strobe when peak_est is refreshed |
| cmd_out | output | 16 | Ramped DC-link voltage command, 1/8 V per LSB |

## Verification
The main function is first driven with constant-level windows at the 90 Vrms and 120 Vrms peaks, which separates the lowest and highest bands. Levels placed just inside and just outside the hysteresis margin of the top edge then show whether a band holds or drops. A full-scale window checks that the accumulator is wide enough and that the reciprocal is rounded correctly. Long runs of random strobe density, sample level, measured DC-link voltage and occasional start pulses are checked cycle by cycle against a reference model. These runs show whether window alignment, target timing and the ramp's landing behaviour stay correct when strobes are sparse or restarts land mid-ramp.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  // Peak-domain threshold for band edge k: RMS edge times sqrt(2), approximated as 181/128.
  function automatic int unsigned edge_thr(input int unsigned k,
                                           input int unsigned edge0,
                                           input int unsigned edge_step);
    return ((edge0 + edge_step * k) * 181) / 128;
  endfunction

endpackage

// File: rtl/dcl_peak_avg.sv
module dcl_peak_avg #(
  parameter int unsigned W_DATA   = 16,
  parameter int unsigned N_AVG    = 10000,
  parameter int unsigned RECIP_SH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [W_DATA-1:0] vd_in,
  output logic [W_DATA-1:0] peak,
  output logic              peak_vld
);
  localparam int unsigned W_CNT  = (N_AVG > 1) ? $clog2(N_AVG) : 1;
  localparam int unsigned W_ACC  = W_DATA + W_CNT;
  localparam int unsigned W_RC   = RECIP_SH + 1;
  localparam int unsigned W_PROD = W_ACC + W_RC;
  localparam longint unsigned RC_L = ((64'd1 << RECIP_SH) + 64'(N_AVG) - 64'd1) / 64'(N_AVG);
  localparam logic [W_RC-1:0] RC = W_RC'(RC_L);

  logic [W_ACC-1:0]  acc_q, acc_d, sum_q, sum_d;
  logic [W_CNT-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d, vld_q, vld_d;
  logic [W_DATA-1:0] peak_q, peak_d;
  logic [W_PROD-1:0] prod;
  logic              last;

  assign last = smp_vld && (cnt_q == W_CNT'(N_AVG - 1));
  assign prod = W_PROD'(sum_q) * W_PROD'(RC);

  always_comb begin
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    sum_d  = sum_q;
    pend_d = last;
    vld_d  = pend_q;
    peak_d = peak_q;
    if (smp_vld) begin
      if (last) begin
        acc_d = '0;
        cnt_d = '0;
        sum_d = acc_q + W_ACC'(vd_in);
      end else begin
        acc_d = acc_q + W_ACC'(vd_in);
        cnt_d = cnt_q + W_CNT'(1);
      end
    end
    if (pend_q) begin
      peak_d = prod[RECIP_SH +: W_DATA];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      peak_q <= '0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      sum_q  <= sum_d;
      pend_q <= pend_d;
      vld_q  <= vld_d;
      peak_q <= peak_d;
    end
  end

  assign peak     = peak_q;
  assign peak_vld = vld_q;
endmodule

// File: rtl/dcl_band_sel.sv
module dcl_band_sel #(
  parameter int unsigned W_DATA    = 16,
  parameter int unsigned N_BANDS   = 7,
  parameter int unsigned EDGE0     = 740,
  parameter int unsigned EDGE_STEP = 40,
  parameter int unsigned HYST      = 8,
  parameter int unsigned TGT_BASE  = 1520,
  parameter int unsigned TGT_STEP  = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              peak_vld,
  input  logic [W_DATA-1:0] peak,
  output logic [W_DATA-1:0] tgt,
  output logic              tgt_ok
);
  localparam int unsigned N_EDGES = N_BANDS - 1;
  localparam int unsigned W_BAND  = $clog2(N_BANDS);

  logic [W_BAND-1:0]  band_q, band_d, band_new;
  logic [W_DATA-1:0]  tgt_q, tgt_d;
  logic               ok_q, ok_d;
  logic [N_EDGES-1:0] passed;
  logic [31:0]        pk32;

  assign pk32 = 32'(peak);

  for (genvar k = 0; k < N_EDGES; k++) begin : g_edge
    localparam int unsigned THR = dcl_pkg::edge_thr(k, EDGE0, EDGE_STEP);
    assign passed[k] = (k < int'(band_q)) ? (pk32 + HYST >= THR)
                                          : (pk32 >= THR + HYST);
  end

  always_comb begin
    band_new = '0;
    for (int k = 0; k < N_EDGES; k++) begin
      band_new = band_new + W_BAND'(passed[k]);
    end
  end

  always_comb begin
    band_d = band_q;
    tgt_d  = tgt_q;
    ok_d   = ok_q;
    if (peak_vld) begin
      band_d = band_new;
      tgt_d  = W_DATA'(TGT_BASE + TGT_STEP * 32'(band_new));
      ok_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= '0;
      tgt_q  <= W_DATA'(TGT_BASE);
      ok_q   <= 1'b0;
    end else begin
      band_q <= band_d;
      tgt_q  <= tgt_d;
      ok_q   <= ok_d;
    end
  end

  assign tgt    = tgt_q;
  assign tgt_ok = ok_q;
endmodule

// File: rtl/dcl_ramp.sv
module dcl_ramp #(
  parameter int unsigned W_DATA    = 16,
  parameter int unsigned START_OFS = 160,
  parameter int unsigned RAMP_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              smp_vld,
  input  logic [W_DATA-1:0] vdc_meas,
  input  logic [W_DATA-1:0] tgt,
  input  logic              tgt_ok,
  output logic [W_DATA-1:0] cmd,
  output logic              run
);
  localparam logic [W_DATA-1:0] STEP = W_DATA'(RAMP_STEP);
  localparam logic [W_DATA-1:0] OFS  = W_DATA'(START_OFS);

  logic [W_DATA-1:0] cmd_q, cmd_d, up_gap, dn_gap;
  logic              run_q, run_d, step_en;

  assign up_gap  = tgt - cmd_q;
  assign dn_gap  = cmd_q - tgt;
  assign step_en = run_q && tgt_ok && smp_vld;

  always_comb begin
    cmd_d = cmd_q;
    run_d = run_q;
    if (start) begin
      cmd_d = vdc_meas + OFS;
      run_d = 1'b1;
    end else if (step_en) begin
      if (cmd_q < tgt) begin
        cmd_d = (up_gap > STEP) ? cmd_q + STEP : tgt;
      end else if (cmd_q > tgt) begin
        cmd_d = (dn_gap > STEP) ? cmd_q - STEP : tgt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      run_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      run_q <= run_d;
    end
  end

  assign cmd = cmd_q;
  assign run = run_q;
endmodule

// File: rtl/dcl_cmd_sched.sv
module dcl_cmd_sched #(
  parameter int unsigned W_DATA    = 16,
  parameter int unsigned N_AVG     = 10000,
  parameter int unsigned RECIP_SH  = 32,
  parameter int unsigned N_BANDS   = 7,
  parameter int unsigned EDGE0     = 740,
  parameter int unsigned EDGE_STEP = 40,
  parameter int unsigned HYST      = 8,
  parameter int unsigned TGT_BASE  = 1520,
  parameter int unsigned TGT_STEP  = 80,
  parameter int unsigned START_OFS = 160,
  parameter int unsigned RAMP_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic              start,
  input  logic [W_DATA-1:0] vd_in,
  input  logic [W_DATA-1:0] vdc_meas,
  output logic [W_DATA-1:0] peak_est,
  output logic              peak_vld,
  output logic [W_DATA-1:0] cmd_out
);
  logic [W_DATA-1:0] peak_w, tgt_w, cmd_w;
  logic              pvld_w, ok_w, run_w;

  dcl_peak_avg #(.W_DATA(W_DATA), .N_AVG(N_AVG), .RECIP_SH(RECIP_SH)) avg_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .vd_in(vd_in),
    .peak(peak_w), .peak_vld(pvld_w)
  );

  dcl_band_sel #(
    .W_DATA(W_DATA), .N_BANDS(N_BANDS), .EDGE0(EDGE0), .EDGE_STEP(EDGE_STEP),
    .HYST(HYST), .TGT_BASE(TGT_BASE), .TGT_STEP(TGT_STEP)
  ) band_i (
    .clk(clk), .rst_n(rst_n), .peak_vld(pvld_w), .peak(peak_w),
    .tgt(tgt_w), .tgt_ok(ok_w)
  );

  dcl_ramp #(.W_DATA(W_DATA), .START_OFS(START_OFS), .RAMP_STEP(RAMP_STEP)) ramp_i (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld),
    .vdc_meas(vdc_meas), .tgt(tgt_w), .tgt_ok(ok_w), .cmd(cmd_w), .run(run_w)
  );

  assign peak_est = peak_w;
  assign peak_vld = pvld_w;
  assign cmd_out  = cmd_w;
endmodule

// File: rtl/dcl_cmd_sched_chk.sv
module dcl_cmd_sched_chk #(
  parameter int unsigned W_DATA    = 16,
  parameter int unsigned START_OFS = 160,
  parameter int unsigned RAMP_STEP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              peak_vld,
  input logic [W_DATA-1:0] vdc_meas,
  input logic [W_DATA-1:0] cmd,
  input logic [W_DATA-1:0] tgt,
  input logic              run
);
  // R2: the estimate strobe lasts a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    peak_vld |=> !peak_vld);

  // R5: target moves only on an edge that samples the estimate strobe
  a_r5_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_vld |=> $stable(tgt));

  // R6: start loads measured voltage plus offset
  a_r6_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cmd == W_DATA'($past(vdc_meas) + W_DATA'(START_OFS))));

  // R7: per-edge command change bounded by the ramp step
  a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=>
      (((cmd >= $past(cmd)) ? (cmd - $past(cmd)) : ($past(cmd) - cmd)) <= W_DATA'(RAMP_STEP)));

  // R7: rising command never crosses a steady target
  a_r7_no_cross_up: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !peak_vld && (cmd <= tgt)) |=> (cmd <= tgt));

  // R7: falling command never crosses a steady target
  a_r7_no_cross_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !peak_vld && (cmd >= tgt)) |=> (cmd >= tgt));

  // R8: no command before the first start
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> (cmd == '0));
endmodule

bind dcl_cmd_sched dcl_cmd_sched_chk #(
  .W_DATA(W_DATA), .START_OFS(START_OFS), .RAMP_STEP(RAMP_STEP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .peak_vld(peak_vld),
  .vdc_meas(vdc_meas), .cmd(cmd_out), .tgt(tgt_w), .run(run_w)
);

// File: tb/dcl_cmd_sched_tb.sv
module dcl_cmd_sched_tb_top;
  localparam int N = 200;

  logic        clk, rst_n, smp_vld, start;
  logic [15:0] vd_in, vdc_meas, peak_est, cmd_out;
  logic        peak_vld;

  int n_chk, n_fail;
  bit done;

  // reference model state
  longint m_acc, m_sum;
  int m_cnt, m_peak, m_band, m_tgt, m_cmd;
  bit m_pend, m_vld, m_ok, m_run;

  dcl_cmd_sched #(.N_AVG(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .start(start),
    .vd_in(vd_in), .vdc_meas(vdc_meas), .peak_est(peak_est),
    .peak_vld(peak_vld), .cmd_out(cmd_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int f_mean(longint s);
    longint rc = ((64'd1 << 32) + N - 1) / N;
    return int'((s * rc) >> 32);
  endfunction

  function automatic int f_band(int p, int b);
    int n = 0;
    for (int k = 0; k < 6; k++) begin
      int thr = ((740 + 40 * k) * 181) / 128;
      if (k < b) begin
        if (p + 8 >= thr) n++;
      end else if (p >= thr + 8) n++;
    end
    return n;
  endfunction

  function automatic int f_tgt(int b);
    return 1520 + 80 * b;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_sum = 0; m_cnt = 0; m_peak = 0; m_band = 0;
    m_tgt = 1520; m_cmd = 0; m_pend = 0; m_vld = 0; m_ok = 0; m_run = 0;
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(bit v, int d, bit s, int vc);
    longint n_acc, n_sum;
    int n_cnt, n_peak, n_band, n_tgt, n_cmd;
    bit n_pend, n_vld, n_ok, n_run, lst;
    smp_vld = v; vd_in = 16'(d); start = s; vdc_meas = 16'(vc);
    @(posedge clk);
    @(negedge clk);
    lst = v && (m_cnt == N - 1);
    n_acc = m_acc; n_cnt = m_cnt; n_sum = m_sum;
    if (v) begin
      if (lst) begin n_acc = 0; n_cnt = 0; n_sum = m_acc + d; end
      else begin n_acc = m_acc + d; n_cnt = m_cnt + 1; end
    end
    n_pend = lst;
    n_vld  = m_pend;
    n_peak = m_pend ? f_mean(m_sum) : m_peak;
    n_band = m_vld ? f_band(m_peak, m_band) : m_band;
    n_tgt  = m_vld ? f_tgt(n_band) : m_tgt;
    n_ok   = m_ok | m_vld;
    n_cmd  = m_cmd; n_run = m_run;
    if (s) begin n_cmd = (vc + 160) & 16'hFFFF; n_run = 1; end
    else if (m_run && m_ok && v) begin
      if (m_cmd < m_tgt) n_cmd = (m_tgt - m_cmd > 2) ? m_cmd + 2 : m_tgt;
      else if (m_cmd > m_tgt) n_cmd = (m_cmd - m_tgt > 2) ? m_cmd - 2 : m_tgt;
    end
    m_acc = n_acc; m_cnt = n_cnt; m_sum = n_sum; m_pend = n_pend; m_vld = n_vld;
    m_peak = n_peak; m_band = n_band; m_tgt = n_tgt; m_ok = n_ok;
    m_cmd = n_cmd; m_run = n_run;
    check("R2 strobe", peak_vld, m_vld);
    check("R3 mean", peak_est, m_peak);
    check("R7 ramp", cmd_out, m_cmd);
  endtask

  task automatic level(int d, int wins);
    for (int i = 0; i < wins * N; i++) cyc(1'b1, d, 1'b0, 1400);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; smp_vld = 1'b0; start = 1'b0; vd_in = '0; vdc_meas = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 peak", peak_est, 0);
    check("R1 vld", peak_vld, 0);
    check("R1 cmd", cmd_out, 0);
    rst_n = 1'b1;
    cyc(1'b0, 0, 1'b0, 0);
    check("R1 cmd after release", cmd_out, 0);

    // R8: a full window before start leaves the command at zero
    level(1018, 1);
    cyc(1'b0, 0, 1'b0, 1400);
    cyc(1'b0, 0, 1'b0, 1400);
    check("R8 idle cmd", cmd_out, 0);
    check("R3 constant 90V peak", peak_est, 1018);

    // R6: start loads vdc + 20 V
    cyc(1'b0, 0, 1'b1, 1400);
    check("R6 start load", cmd_out, 1560);
    level(1018, 1);
    check("R7 landed on 190V", cmd_out, 1520);

    // R5: top band target
    level(1358, 3);
    check("R5 top band target", cmd_out, 2000);

    // R4: inside hysteresis margin of top edge holds band 6
    level(1325, 2);
    check("R4 hold band 6", cmd_out, 2000);
    // R4: below margin drops to band 5
    level(1318, 2);
    check("R4 drop to band 5", cmd_out, 1920);
    // R4: above threshold but inside margin keeps band 5
    level(1334, 2);
    check("R4 hold band 5", cmd_out, 1920);

    // R3: full-scale window without overflow
    level(65535, 1);
    cyc(1'b0, 0, 1'b0, 1400);
    cyc(1'b0, 0, 1'b0, 1400);
    check("R3 full scale", peak_est, 65535);

    // random: strobe density, levels, restarts
    for (int i = 0; i < 40000; i++) begin
      bit v = ($urandom % 100) < 60;
      int d = 1000 + int'($urandom % 400);
      bit s = ($urandom % 4000) == 0;
      int vc = 1200 + int'($urandom % 600);
      cyc(v, d, s, vc);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule